// File: doc/BRIEF.md
# Context-Tagged Translation Cache with Walk, Fault and Write-Back Handling

This block is a small fully associative cache of page translations that sits between a requester and an external page walker. Each lookup presents a virtual page number, a context tag and an access kind. When a resident entry matches both the page and the context, the block checks the access against that entry's permission bits. It then returns the frame number, or it flags a protection fault. Because the context is part of the match, translations of different address spaces sit side by side, and switching context needs no flush.

On a miss the block holds a walk request until the walker acknowledges it. If the walker reports an unmapped page, the block answers with a page fault and installs nothing. Otherwise it installs the translation and answers in the cycle after the acknowledge. Installation uses a free slot if there is one. If every slot is occupied, a round-robin victim is displaced, and the victim's tag, frame and modified flag are pushed out on a write-back strobe so the page table can be updated. Commands from the operating system clear all entries, the entries of one context, or one page of one context.

Top module: `xlat_cache`

## Requirements
- R1: After reset, req_ready_o is 1 and rsp_valid_o, walk_req_o and wb_valid_o are 0. Every slot is empty, so the first lookup of any page walks.
- R2: A request accepted while req_ready_o is 1 that matches a valid entry on both page and context produces rsp_valid_o one cycle later. The entry's frame appears on rsp_pfn_o and no walk is issued.
- R3: The access kind is encoded as 0 = read, 1 = write and 2 = execute, and it is permitted when permission bit 0, 1 or 2 respectively is set. A denied access raises rsp_prot_fault_o with rsp_pfn_o = 0. This applies to hits and to freshly installed entries.
- R4: On a miss, walk_req_o rises one cycle after acceptance, carrying the page and context, and stays high until walk_ack_i. The response appears in the cycle after the acknowledge, and req_ready_o stays low meanwhile.
- R5: A walk answered with walk_mapped_i = 0 raises rsp_page_fault_o with rsp_pfn_o = 0, installs nothing and produces no write-back, so the same lookup walks again.
- R6: A mapped walk result is installed in the lowest-numbered empty slot. If no slot is empty, it goes into the slot named by a round-robin pointer that starts at slot 0 and advances by one after each displacement.
- R7: Displacing a valid entry pulses wb_valid_o in the same cycle as the response, carrying the displaced entry's page, context, frame and modified flag.
- R8: A permitted write to an entry sets its modified flag. An installed entry starts with the walker's modified flag, OR-ed with 1 when the installing access is a permitted write.
- R9: The same page under two contexts occupies two independent entries, and each is hit only by its own context.
- R10: Command code 1 on cmd_op_i while idle clears every entry in one cycle.
- R11: Command code 2 while idle clears only the entries whose context equals cmd_ctx_i.
- R12: Command code 3 while idle clears only the entry whose page and context equal cmd_vpn_i and cmd_ctx_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request strobe |
| req_vpn_i | input | VPN_W | Virtual page number |
| req_ctx_i | input | CTX_W | Context tag of the request |
| req_acc_i | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| req_ready_o | output | 1 | Idle and accepting requests and commands |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_pfn_o | output | PFN_W | Frame number, 0 on any fault |
| rsp_prot_fault_o | output | 1 | Access denied by permission bits |
| rsp_page_fault_o | output | 1 | Page not mapped |
| walk_req_o | output | 1 | Walk request, held until acknowledged |
| walk_vpn_o | output | VPN_W | Page to walk |
| walk_ctx_o | output | CTX_W | Context to walk |
| walk_ack_i | input | 1 | Walk result strobe |
| walk_mapped_i | input | 1 | Page is mapped |
| walk_pfn_i | input | PFN_W | Frame from the walk |
| walk_perm_i | input | 3 | Permissions: bit 0 read, bit 1 write, bit 2 execute |
| walk_dirty_i | input | 1 | Modified flag held by the page table |
| wb_valid_o | output | 1 | Displaced entry write-back strobe |
| wb_vpn_o | output | VPN_W | Displaced page |
| wb_ctx_o | output | CTX_W | Displaced context |
| wb_pfn_o | output | PFN_W | Displaced frame |
| wb_dirty_o | output | 1 | Displaced modified flag |
| cmd_op_i | input | 2 | 0 none, 1 clear all, 2 clear context, 3 clear page |
| cmd_vpn_i | input | VPN_W | Page for code 3 |
| cmd_ctx_i | input | CTX_W | Context for codes 2 and 3 |

## Verification
A wrong valid bit or tag first shows as a walk where a hit was due, or as a missing walk, in the cycle right after the request is accepted. A wrong frame or permission field shows on rsp_pfn_o or a fault flag in that same cycle. A lost modified flag or a misplaced round-robin pointer stays hidden until the entry is displaced, which can be many lookups later. It then appears as a wrong page or flag on the write-back strobe. The sweeps therefore fill the cache past capacity several times, so every slot is displaced after writes with mixed permissions.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int PERM_W = 3;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2
  } acc_e;

  typedef enum logic [1:0] {
    CMD_NONE       = 2'd0,
    CMD_FLUSH_ALL  = 2'd1,
    CMD_FLUSH_CTX  = 2'd2,
    CMD_INVAL_PAGE = 2'd3
  } cmd_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WALK = 1'b1
  } state_e;

  function automatic logic acc_ok(input logic [PERM_W-1:0] perm, input logic [1:0] acc);
    case (acc)
      2'd0:    return perm[0];
      2'd1:    return perm[1];
      2'd2:    return perm[2];
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/xlat_entry_store.sv
module xlat_entry_store
  import xlat_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int VPN_W = 8,
  parameter int PFN_W = 6,
  parameter int CTX_W = 3,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [VPN_W-1:0]               lk_vpn_i,
  input  logic [CTX_W-1:0]               lk_ctx_i,
  output logic [DEPTH-1:0]               hit_vec_o,
  input  logic                           flush_all_i,
  input  logic                           flush_ctx_i,
  input  logic                           inval_page_i,
  input  logic [VPN_W-1:0]               cmd_vpn_i,
  input  logic [CTX_W-1:0]               cmd_ctx_i,
  input  logic                           set_dirty_i,
  input  logic [IDX_W-1:0]               set_dirty_idx_i,
  input  logic                           ins_i,
  input  logic [IDX_W-1:0]               ins_idx_i,
  input  logic [VPN_W-1:0]               ins_vpn_i,
  input  logic [CTX_W-1:0]               ins_ctx_i,
  input  logic [PFN_W-1:0]               ins_pfn_i,
  input  logic [PERM_W-1:0]              ins_perm_i,
  input  logic                           ins_dirty_i,
  output logic [DEPTH-1:0]               valid_o,
  output logic [DEPTH-1:0][VPN_W-1:0]    vpn_o,
  output logic [DEPTH-1:0][CTX_W-1:0]    ctx_o,
  output logic [DEPTH-1:0][PFN_W-1:0]    pfn_o,
  output logic [DEPTH-1:0][PERM_W-1:0]   perm_o,
  output logic [DEPTH-1:0]               dirty_o
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic ins_here, kill;
    assign ins_here = ins_i && (ins_idx_i == IDX_W'(i));
    assign kill = flush_all_i
                || (flush_ctx_i && ctx_o[i] == cmd_ctx_i)
                || (inval_page_i && ctx_o[i] == cmd_ctx_i && vpn_o[i] == cmd_vpn_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o[i] <= 1'b0;
        vpn_o[i]   <= '0;
        ctx_o[i]   <= '0;
        pfn_o[i]   <= '0;
        perm_o[i]  <= '0;
        dirty_o[i] <= 1'b0;
      end else if (ins_here) begin
        valid_o[i] <= 1'b1;
        vpn_o[i]   <= ins_vpn_i;
        ctx_o[i]   <= ins_ctx_i;
        pfn_o[i]   <= ins_pfn_i;
        perm_o[i]  <= ins_perm_i;
        dirty_o[i] <= ins_dirty_i;
      end else begin
        if (kill) valid_o[i] <= 1'b0;
        if (set_dirty_i && set_dirty_idx_i == IDX_W'(i)) dirty_o[i] <= 1'b1;
      end
    end

    assign hit_vec_o[i] = valid_o[i] && vpn_o[i] == lk_vpn_i && ctx_o[i] == lk_ctx_i;
  end

  assert_single_hit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec_o));

  assert_flush_all_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_all_i && !ins_i |=> valid_o == '0);

endmodule

// File: rtl/xlat_victim_sel.sv
module xlat_victim_sel #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DEPTH-1:0] valid_i,
  input  logic             adv_i,
  output logic [IDX_W-1:0] victim_o,
  output logic             victim_valid_o
);

  logic [IDX_W-1:0] free_idx, rr_q;
  logic             all_valid;

  assign all_valid = &valid_i;

  always_comb begin
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!valid_i[i]) free_idx = IDX_W'(i);
  end

  assign victim_o       = all_valid ? rr_q : free_idx;
  assign victim_valid_o = all_valid;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rr_q <= '0;
    else if (adv_i && all_valid) rr_q <= (rr_q == IDX_W'(DEPTH - 1)) ? '0 : rr_q + 1'b1;
  end

  assert_victim_free_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !all_valid |-> !valid_i[victim_o]);

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int VPN_W = 8,
  parameter int PFN_W = 6,
  parameter int CTX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [VPN_W-1:0] req_vpn_i,
  input  logic [CTX_W-1:0] req_ctx_i,
  input  logic [1:0]       req_acc_i,
  output logic             req_ready_o,
  output logic             rsp_valid_o,
  output logic [PFN_W-1:0] rsp_pfn_o,
  output logic             rsp_prot_fault_o,
  output logic             rsp_page_fault_o,
  output logic             walk_req_o,
  output logic [VPN_W-1:0] walk_vpn_o,
  output logic [CTX_W-1:0] walk_ctx_o,
  input  logic             walk_ack_i,
  input  logic             walk_mapped_i,
  input  logic [PFN_W-1:0] walk_pfn_i,
  input  logic [2:0]       walk_perm_i,
  input  logic             walk_dirty_i,
  output logic             wb_valid_o,
  output logic [VPN_W-1:0] wb_vpn_o,
  output logic [CTX_W-1:0] wb_ctx_o,
  output logic [PFN_W-1:0] wb_pfn_o,
  output logic             wb_dirty_o,
  input  logic [1:0]       cmd_op_i,
  input  logic [VPN_W-1:0] cmd_vpn_i,
  input  logic [CTX_W-1:0] cmd_ctx_i
);

  localparam int IDX_W = $clog2(DEPTH);

  state_e           state_q;
  logic [VPN_W-1:0] cap_vpn_q;
  logic [CTX_W-1:0] cap_ctx_q;
  logic [1:0]       cap_acc_q;

  logic [DEPTH-1:0]              hit_vec, valid;
  logic [DEPTH-1:0][VPN_W-1:0]   e_vpn;
  logic [DEPTH-1:0][CTX_W-1:0]   e_ctx;
  logic [DEPTH-1:0][PFN_W-1:0]   e_pfn;
  logic [DEPTH-1:0][PERM_W-1:0]  e_perm;
  logic [DEPTH-1:0]              e_dirty;
  logic [IDX_W-1:0]              hit_idx, victim;
  logic                          victim_valid;

  logic idle, accept, hit, hit_ok, walk_done, ins, walk_ok, set_dirty;
  logic flush_all, flush_ctx, inval_page;

  assign idle      = (state_q == ST_IDLE);
  assign accept    = idle && req_valid_i;
  assign hit       = |hit_vec;
  assign walk_done = (state_q == ST_WALK) && walk_ack_i;
  assign ins       = walk_done && walk_mapped_i;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < DEPTH; i++)
      if (hit_vec[i]) hit_idx |= IDX_W'(i);
  end

  assign hit_ok    = acc_ok(e_perm[hit_idx], req_acc_i);
  assign walk_ok   = acc_ok(walk_perm_i, cap_acc_q);
  assign set_dirty = accept && hit && hit_ok && req_acc_i == ACC_WRITE;

  assign flush_all  = idle && cmd_op_i == CMD_FLUSH_ALL;
  assign flush_ctx  = idle && cmd_op_i == CMD_FLUSH_CTX;
  assign inval_page = idle && cmd_op_i == CMD_INVAL_PAGE;

  xlat_entry_store #(
    .DEPTH(DEPTH), .VPN_W(VPN_W), .PFN_W(PFN_W), .CTX_W(CTX_W)
  ) u_store (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .lk_vpn_i       (req_vpn_i),
    .lk_ctx_i       (req_ctx_i),
    .hit_vec_o      (hit_vec),
    .flush_all_i    (flush_all),
    .flush_ctx_i    (flush_ctx),
    .inval_page_i   (inval_page),
    .cmd_vpn_i      (cmd_vpn_i),
    .cmd_ctx_i      (cmd_ctx_i),
    .set_dirty_i    (set_dirty),
    .set_dirty_idx_i(hit_idx),
    .ins_i          (ins),
    .ins_idx_i      (victim),
    .ins_vpn_i      (cap_vpn_q),
    .ins_ctx_i      (cap_ctx_q),
    .ins_pfn_i      (walk_pfn_i),
    .ins_perm_i     (walk_perm_i),
    .ins_dirty_i    (walk_dirty_i || (cap_acc_q == ACC_WRITE && walk_ok)),
    .valid_o        (valid),
    .vpn_o          (e_vpn),
    .ctx_o          (e_ctx),
    .pfn_o          (e_pfn),
    .perm_o         (e_perm),
    .dirty_o        (e_dirty)
  );

  xlat_victim_sel #(.DEPTH(DEPTH)) u_victim (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .valid_i       (valid),
    .adv_i         (ins),
    .victim_o      (victim),
    .victim_valid_o(victim_valid)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q          <= ST_IDLE;
      cap_vpn_q        <= '0;
      cap_ctx_q        <= '0;
      cap_acc_q        <= '0;
      rsp_valid_o      <= 1'b0;
      rsp_pfn_o        <= '0;
      rsp_prot_fault_o <= 1'b0;
      rsp_page_fault_o <= 1'b0;
      wb_valid_o       <= 1'b0;
      wb_vpn_o         <= '0;
      wb_ctx_o         <= '0;
      wb_pfn_o         <= '0;
      wb_dirty_o       <= 1'b0;
    end else begin
      rsp_valid_o      <= 1'b0;
      rsp_prot_fault_o <= 1'b0;
      rsp_page_fault_o <= 1'b0;
      wb_valid_o       <= 1'b0;
      if (accept) begin
        if (hit) begin
          rsp_valid_o      <= 1'b1;
          rsp_prot_fault_o <= !hit_ok;
          rsp_pfn_o        <= hit_ok ? e_pfn[hit_idx] : '0;
        end else begin
          state_q   <= ST_WALK;
          cap_vpn_q <= req_vpn_i;
          cap_ctx_q <= req_ctx_i;
          cap_acc_q <= req_acc_i;
        end
      end else if (walk_done) begin
        state_q     <= ST_IDLE;
        rsp_valid_o <= 1'b1;
        if (walk_mapped_i) begin
          rsp_prot_fault_o <= !walk_ok;
          rsp_pfn_o        <= walk_ok ? walk_pfn_i : '0;
          wb_valid_o       <= victim_valid;
          wb_vpn_o         <= e_vpn[victim];
          wb_ctx_o         <= e_ctx[victim];
          wb_pfn_o         <= e_pfn[victim];
          wb_dirty_o       <= e_dirty[victim];
        end else begin
          rsp_page_fault_o <= 1'b1;
          rsp_pfn_o        <= '0;
        end
      end
    end
  end

  assign req_ready_o = idle;
  assign walk_req_o  = (state_q == ST_WALK);
  assign walk_vpn_o  = cap_vpn_q;
  assign walk_ctx_o  = cap_ctx_q;

  assert_walk_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    walk_req_o && !walk_ack_i |=> walk_req_o && $stable(walk_vpn_o));

  assert_ack_rsp_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    walk_req_o && walk_ack_i |=> rsp_valid_o && req_ready_o);

  assert_fault_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_prot_fault_o || rsp_page_fault_o) |-> rsp_valid_o && !(rsp_prot_fault_o && rsp_page_fault_o));

  assert_pf_no_wb_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_page_fault_o |-> !wb_valid_o && rsp_pfn_o == '0);

  assert_wb_with_rsp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> rsp_valid_o);

endmodule

// File: tb/tb_xlat_cache.sv
`timescale 1ns/1ps
module tb_xlat_cache;
  localparam int D = 16, VW = 8, PW = 6, CW = 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 0; logic [VW-1:0] req_vpn_i = 0; logic [CW-1:0] req_ctx_i = 0; logic [1:0] req_acc_i = 0;
  logic req_ready_o, rsp_valid_o, rsp_prot_fault_o, rsp_page_fault_o;
  logic [PW-1:0] rsp_pfn_o;
  logic walk_req_o; logic [VW-1:0] walk_vpn_o; logic [CW-1:0] walk_ctx_o;
  logic walk_ack_i = 0, walk_mapped_i = 0, walk_dirty_i = 0;
  logic [PW-1:0] walk_pfn_i = 0; logic [2:0] walk_perm_i = 0;
  logic wb_valid_o, wb_dirty_o; logic [VW-1:0] wb_vpn_o; logic [CW-1:0] wb_ctx_o; logic [PW-1:0] wb_pfn_o;
  logic [1:0] cmd_op_i = 0; logic [VW-1:0] cmd_vpn_i = 0; logic [CW-1:0] cmd_ctx_i = 0;

  always #2.5 clk = ~clk;

  xlat_cache #(.DEPTH(D), .VPN_W(VW), .PFN_W(PW), .CTX_W(CW)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_vpn_i(req_vpn_i), .req_ctx_i(req_ctx_i), .req_acc_i(req_acc_i),
    .req_ready_o(req_ready_o), .rsp_valid_o(rsp_valid_o), .rsp_pfn_o(rsp_pfn_o),
    .rsp_prot_fault_o(rsp_prot_fault_o), .rsp_page_fault_o(rsp_page_fault_o),
    .walk_req_o(walk_req_o), .walk_vpn_o(walk_vpn_o), .walk_ctx_o(walk_ctx_o),
    .walk_ack_i(walk_ack_i), .walk_mapped_i(walk_mapped_i), .walk_pfn_i(walk_pfn_i),
    .walk_perm_i(walk_perm_i), .walk_dirty_i(walk_dirty_i),
    .wb_valid_o(wb_valid_o), .wb_vpn_o(wb_vpn_o), .wb_ctx_o(wb_ctx_o), .wb_pfn_o(wb_pfn_o),
    .wb_dirty_o(wb_dirty_o), .cmd_op_i(cmd_op_i), .cmd_vpn_i(cmd_vpn_i), .cmd_ctx_i(cmd_ctx_i)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference state built from the requirements
  bit m_v[D]; bit m_d[D];
  int m_vpn[D], m_ctx[D], m_pfn[D], m_perm[D];
  int rr = 0;

  function automatic bit pt_mapped(int v); return (v % 8) != 7; endfunction
  function automatic int pt_pfn(int v, int c); return (v * 3 + c * 7) % 64; endfunction
  function automatic int pt_perm(int v, int c); return ((v >> 1) ^ c) & 7; endfunction
  function automatic bit pt_dirty(int v); return bit'((v >> 4) & 1); endfunction
  function automatic bit perm_ok(int p, int a); return (a < 3) ? bit'((p >> a) & 1) : 1'b0; endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic access(int vpn, int ctx, int acc, string wtag);
    int hi = -1, vi = 0, guard = 0;
    bit e_walk, e_pf = 0, e_prot = 0, e_wb = 0, e_wbd = 0, ok, walked = 0;
    int e_pfn = 0, e_wbv = 0, e_wbc = 0, e_wbp = 0;
    for (int i = 0; i < D; i++) if (m_v[i] && m_vpn[i] == vpn && m_ctx[i] == ctx) hi = i;
    if (hi >= 0) begin
      e_walk = 0; ok = perm_ok(m_perm[hi], acc);
      e_prot = !ok; e_pfn = ok ? m_pfn[hi] : 0;
      if (ok && acc == 1) m_d[hi] = 1;
    end else begin
      e_walk = 1;
      if (!pt_mapped(vpn)) e_pf = 1;
      else begin
        vi = -1;
        for (int i = D - 1; i >= 0; i--) if (!m_v[i]) vi = i;
        if (vi < 0) begin vi = rr; rr = (rr + 1) % D; end
        e_wb = m_v[vi]; e_wbv = m_vpn[vi]; e_wbc = m_ctx[vi]; e_wbp = m_pfn[vi]; e_wbd = m_d[vi];
        ok = perm_ok(pt_perm(vpn, ctx), acc);
        m_v[vi] = 1; m_vpn[vi] = vpn; m_ctx[vi] = ctx; m_pfn[vi] = pt_pfn(vpn, ctx);
        m_perm[vi] = pt_perm(vpn, ctx); m_d[vi] = pt_dirty(vpn) | (ok && acc == 1);
        e_prot = !ok; e_pfn = ok ? pt_pfn(vpn, ctx) : 0;
      end
    end
    @(negedge clk);
    req_valid_i = 1; req_vpn_i = VW'(vpn); req_ctx_i = CW'(ctx); req_acc_i = 2'(acc);
    @(negedge clk);
    req_valid_i = 0;
    while (!rsp_valid_o && guard < 50) begin
      if (walk_req_o && !walk_ack_i) begin
        walked = 1;
        chk("R4 walk page", int'(walk_vpn_o), vpn);
        chk("R4 ready low in walk", int'(req_ready_o), 0);
        walk_ack_i = 1; walk_mapped_i = pt_mapped(int'(walk_vpn_o));
        walk_pfn_i = PW'(pt_pfn(int'(walk_vpn_o), int'(walk_ctx_o)));
        walk_perm_i = 3'(pt_perm(int'(walk_vpn_o), int'(walk_ctx_o)));
        walk_dirty_i = pt_dirty(int'(walk_vpn_o));
      end else walk_ack_i = 0;
      @(negedge clk);
      guard++;
    end
    walk_ack_i = 0;
    chk(wtag, int'(walked), int'(e_walk));
    chk("R2 rsp valid", int'(rsp_valid_o), 1);
    chk("R3 prot fault", int'(rsp_prot_fault_o), int'(e_prot));
    chk("R5 page fault", int'(rsp_page_fault_o), int'(e_pf));
    chk("R2 pfn", int'(rsp_pfn_o), e_pfn);
    chk("R7 wb valid", int'(wb_valid_o), int'(e_wb));
    if (e_wb) begin
      chk("R6 victim page", int'(wb_vpn_o), e_wbv);
      chk("R7 wb ctx", int'(wb_ctx_o), e_wbc);
      chk("R7 wb pfn", int'(wb_pfn_o), e_wbp);
      chk("R8 wb dirty", int'(wb_dirty_o), int'(e_wbd));
    end
  endtask

  task automatic command(int op, int vpn, int ctx);
    @(negedge clk);
    cmd_op_i = 2'(op); cmd_vpn_i = VW'(vpn); cmd_ctx_i = CW'(ctx);
    @(negedge clk);
    cmd_op_i = 0;
    for (int i = 0; i < D; i++)
      if (op == 1 || (op == 2 && m_ctx[i] == ctx) || (op == 3 && m_ctx[i] == ctx && m_vpn[i] == vpn))
        m_v[i] = 0;
  endtask

  initial begin
    for (int i = 0; i < D; i++) begin m_v[i] = 0; m_d[i] = 0; m_vpn[i] = 0; m_ctx[i] = 0; m_pfn[i] = 0; m_perm[i] = 0; end
    repeat (3) @(negedge clk);
    chk("R1 ready", int'(req_ready_o), 1);
    chk("R1 rsp", int'(rsp_valid_o), 0);
    chk("R1 walk", int'(walk_req_o), 0);
    chk("R1 wb", int'(wb_valid_o), 0);
    rst_ni = 1;
    // fill past capacity, then hit and displace with every access kind
    for (int v = 0; v < 20; v++) access(v, 0, 0, "R1 R4 walk on fill");
    for (int a = 0; a < 3; a++)
      for (int v = 0; v < 24; v++) access(v, 0, a, "R2 R6 walk vs hit");
    for (int a = 1; a >= 0; a--)
      for (int v = 10; v < 30; v++) access(v, 0, a, "R8 dirty sweep");
    // same pages under several contexts
    for (int c = 1; c < 4; c++)
      for (int v = 0; v < 5; v++) access(v, c, 1, "R9 ctx install");
    for (int c = 3; c >= 1; c--)
      for (int v = 0; v < 5; v++) access(v, c, 0, "R9 ctx hit");
    command(3, 2, 2);
    access(2, 2, 0, "R12 inval page walks");
    access(2, 1, 0, "R12 other ctx kept");
    access(3, 2, 0, "R12 other page kept");
    command(2, 3, 1);
    for (int c = 1; c < 4; c++)
      for (int v = 0; v < 5; v++) access(v, c, 2, "R11 ctx flush");
    command(1, 0, 0);
    for (int c = 1; c < 4; c++)
      for (int v = 0; v < 3; v++) access(v, c, 0, "R10 flush all");
    for (int v = 0; v < 20; v++) access(v, 5, 1, "R5 R6 refill");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule